// File: doc/BRIEF.md
# Turbo Energy Budget Controller

This block is a hardware governor for core frequency above the guaranteed operating point. On each interval strobe it takes the ratio the operating system asks for, the power measured over the interval just ended, a programmable sustained power limit and the number of active cores. From these it produces the core frequency ratio. It also keeps an energy credit. The credit fills while measured power stays under the limit and drains while power runs above it. The cores can therefore burst above the sustained limit for a bounded time and then fall back to it.

Requests at or below the guaranteed ratio (P1) are followed directly, down to the energy-efficient floor (Pn). A request above P1 hands control of the P1-to-maximum range to the hardware. The hardware then climbs one bin per interval while credit remains, up to a ceiling that rises as fewer cores are active. Once the credit is gone and power still exceeds the limit, it falls one bin per interval back toward P1. A separate thermal input overrides all of this and pins the ratio at Pn.

Top module: `turbo_gov`

## Requirements
- R1: After a synchronous active-low reset, `ratio_out` equals PN_RATIO (default 12) and the energy credit is zero.
- R2: The credit changes only in a cycle where `tick` is high. It then becomes credit + `pwr_limit` − `pwr_meas`, clamped to at least 0 and at most `budget_cap`.
- R3: On a tick with no thermal override and `req_ratio` ≤ P1_RATIO (default 30), the ratio becomes `req_ratio`, or PN_RATIO if the request is lower than that.
- R4: On a tick with `req_ratio` > P1_RATIO while the current ratio is below P1_RATIO, the ratio jumps to P1_RATIO.
- R5: On a turbo-request tick, if the credit before the tick is above zero and the ratio is below the ceiling, the ratio rises by exactly one.
- R6: The ceiling depends on `active_cores`: 1 gives 40, 2 gives 38, 3 gives 36, 4 gives 34. A value of 0 uses the 1-core entry and values 5 to 7 use the 4-core entry. On a turbo-request tick with the ratio above the ceiling, the ratio drops straight to the ceiling.
- R7: On a turbo-request tick with zero credit and `pwr_meas` > `pwr_limit`, the ratio falls by one, but never below P1_RATIO. With zero credit and `pwr_meas` ≤ `pwr_limit`, it holds.
- R8: While `thermal_hot` is high, the ratio is PN_RATIO from the next clock edge on, whether or not `tick` is high.
- R9: Without a tick and without `thermal_hot`, the ratio does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle strobe marking the end of an interval |
| req_ratio | input | RW | Ratio requested by the operating system |
| pwr_meas | input | PW | Power measured over the interval just ended |
| pwr_limit | input | PW | Sustained power limit |
| budget_cap | input | BW | Upper bound on the energy credit |
| active_cores | input | 3 | Number of cores not power-gated |
| thermal_hot | input | 1 | Throttle override; forces the floor ratio |
| ratio_out | output | RW | Core frequency ratio |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that `pwr_meas` and `pwr_limit` are stable in the tick cycle. They also assume that `budget_cap` is held between ticks, because each tick clamps the credit against the cap in force at that edge. The bench changes every input only at a falling edge and raises `tick` for exactly one cycle. The energy credit is never read directly: its effect is inferred from whether the ratio climbs, holds or falls on the ticks that follow.

// File: rtl/turbo_pkg.sv
// Package turbo_pkg: shared helpers for the turbo governor.
// Assumes a four-row ceiling table indexed by active core count.
package turbo_pkg;

    localparam int CORE_ROWS = 4;

    typedef logic [1:0] row_idx_t;

    // Map an active core count onto a table row: 0 and 1 give row 0, 4 and above give row 3.
    function automatic row_idx_t core_row(input logic [2:0] cores);
        row_idx_t r;
        if (cores <= 3'd1)      r = 2'd0;
        else if (cores >= 3'd4) r = 2'd3;
        else                    r = 2'(cores - 3'd1);
        return r;
    endfunction

endpackage

// File: rtl/turbo_energy_acc.sv
// Module turbo_energy_acc: holds the energy credit.
// On each tick the credit moves by (limit - measured), clamped to [0, cap].
// Assumes PW <= BW, so one interval's delta fits inside the credit width.
module turbo_energy_acc #(
    parameter int PW = 8,
    parameter int BW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] pwr_meas,
    input  logic [PW-1:0] pwr_limit,
    input  logic [BW-1:0] budget_cap,
    output logic          budget_pos
);
    localparam int SW = BW + 2;

    logic [BW-1:0]        credit_q;
    logic signed [SW-1:0] raw_sum;
    logic [BW-1:0]        credit_nxt;

    // Signed sum of the credit and this interval's headroom.
    always_comb begin
        raw_sum = $signed({2'b00, credit_q})
                + $signed({{(SW-PW){1'b0}}, pwr_limit})
                - $signed({{(SW-PW){1'b0}}, pwr_meas});
    end

    // Saturate the sum at zero and at the programmed cap.
    always_comb begin
        if (raw_sum < 0)
            credit_nxt = '0;
        else if (raw_sum > $signed({2'b00, budget_cap}))
            credit_nxt = budget_cap;
        else
            credit_nxt = raw_sum[BW-1:0];
    end

    // Credit register, updated only on the interval strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    credit_q <= '0;
        else if (tick) credit_q <= credit_nxt;
    end

    assign budget_pos = (credit_q != '0);

    // R2
    credit_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> credit_q <= $past(budget_cap));

    // R2
    credit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(credit_q));

endmodule

// File: rtl/turbo_ceiling.sv
// Module turbo_ceiling: looks up the maximum turbo ratio for the active core count.
// The table is packed with row 0 (one core) in the low bits. Entries are raised to P1 if lower.
module turbo_ceiling #(
    parameter int RW       = 8,
    parameter int P1_RATIO = 30,
    parameter logic [4*RW-1:0] CEIL_TBL = {8'd34, 8'd36, 8'd38, 8'd40}
) (
    input  logic [2:0]    active_cores,
    output logic [RW-1:0] ceil_ratio
);
    import turbo_pkg::*;

    localparam logic [RW-1:0] P1_R = RW'(P1_RATIO);

    logic [RW-1:0] row_val [CORE_ROWS];

    // Unpack each table row, raising it to at least P1.
    for (genvar g = 0; g < CORE_ROWS; g++) begin : g_row
        localparam logic [RW-1:0] ENTRY = CEIL_TBL[g*RW +: RW];
        assign row_val[g] = (ENTRY < P1_R) ? P1_R : ENTRY;
    end

    // Select the row for the current core count.
    always_comb begin
        ceil_ratio = row_val[core_row(active_cores)];
    end

endmodule

// File: rtl/turbo_ratio_step.sv
// Module turbo_ratio_step: the ratio register and its per-interval stepping rules.
// Assumes ceil_ratio >= P1 and P1 >= PN. The thermal input acts in any cycle.
module turbo_ratio_step #(
    parameter int RW       = 8,
    parameter int P1_RATIO = 30,
    parameter int PN_RATIO = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          thermal_hot,
    input  logic [RW-1:0] req_ratio,
    input  logic [RW-1:0] ceil_ratio,
    input  logic          budget_pos,
    input  logic          over_limit,
    output logic [RW-1:0] ratio_q
);
    localparam logic [RW-1:0] P1_R = RW'(P1_RATIO);
    localparam logic [RW-1:0] PN_R = RW'(PN_RATIO);

    logic [RW-1:0] ratio_nxt;
    logic          turbo_req;

    assign turbo_req = (req_ratio > P1_R);

    // Choose the next ratio: throttle first, then the OS range, then the hardware turbo range.
    always_comb begin
        ratio_nxt = ratio_q;
        if (thermal_hot) begin
            ratio_nxt = PN_R;
        end else if (tick) begin
            if (!turbo_req)
                ratio_nxt = (req_ratio < PN_R) ? PN_R : req_ratio;
            else if (ratio_q < P1_R)
                ratio_nxt = P1_R;
            else if (ratio_q > ceil_ratio)
                ratio_nxt = ceil_ratio;
            else if (budget_pos && (ratio_q < ceil_ratio))
                ratio_nxt = ratio_q + 1'b1;
            else if (!budget_pos && over_limit && (ratio_q > P1_R))
                ratio_nxt = ratio_q - 1'b1;
        end
    end

    // Ratio register.
    always_ff @(posedge clk) begin
        if (!rst_n) ratio_q <= PN_R;
        else        ratio_q <= ratio_nxt;
    end

    // R8
    throttle_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_hot |=> ratio_q == PN_R);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !thermal_hot) |=> $stable(ratio_q));

    // R3
    floor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ratio_q >= PN_R);

    // R5
    single_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !thermal_hot && turbo_req && ratio_q >= P1_R && ratio_q < ceil_ratio)
        |=> ratio_q <= $past(ratio_q) + 1'b1);

    // R7
    turbo_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !thermal_hot && turbo_req) |=> ratio_q >= P1_R);

endmodule

// File: rtl/turbo_gov.sv
// Module turbo_gov: top of the turbo governor.
// Ties together the energy credit, the core-count ceiling and the ratio stepper.
// Assumes tick is a single-cycle strobe and the power inputs are valid when it is high.
module turbo_gov #(
    parameter int RW       = 8,
    parameter int PW       = 8,
    parameter int BW       = 12,
    parameter int P1_RATIO = 30,
    parameter int PN_RATIO = 12,
    parameter logic [4*RW-1:0] CEIL_TBL = {8'd34, 8'd36, 8'd38, 8'd40}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] req_ratio,
    input  logic [PW-1:0] pwr_meas,
    input  logic [PW-1:0] pwr_limit,
    input  logic [BW-1:0] budget_cap,
    input  logic [2:0]    active_cores,
    input  logic          thermal_hot,
    output logic [RW-1:0] ratio_out
);
    logic          budget_pos;
    logic [RW-1:0] ceil_ratio;
    logic          over_limit;

    // Flags an interval that ran above the sustained limit.
    assign over_limit = (pwr_meas > pwr_limit);

    turbo_energy_acc #(.PW(PW), .BW(BW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pwr_meas   (pwr_meas),
        .pwr_limit  (pwr_limit),
        .budget_cap (budget_cap),
        .budget_pos (budget_pos)
    );

    turbo_ceiling #(.RW(RW), .P1_RATIO(P1_RATIO), .CEIL_TBL(CEIL_TBL)) u_ceil (
        .active_cores (active_cores),
        .ceil_ratio   (ceil_ratio)
    );

    turbo_ratio_step #(.RW(RW), .P1_RATIO(P1_RATIO), .PN_RATIO(PN_RATIO)) u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .thermal_hot (thermal_hot),
        .req_ratio   (req_ratio),
        .ceil_ratio  (ceil_ratio),
        .budget_pos  (budget_pos),
        .over_limit  (over_limit),
        .ratio_q     (ratio_out)
    );

endmodule

// File: tb/turbo_gov_test.sv
// Bench for turbo_gov: a vector table of ticks, then directed reset, hold and throttle cases.
module turbo_gov_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  req_ratio = '0;
    logic [7:0]  pwr_meas = '0;
    logic [7:0]  pwr_limit = '0;
    logic [11:0] budget_cap = '0;
    logic [2:0]  active_cores = 3'd4;
    logic        thermal_hot = 1'b0;
    logic [7:0]  ratio_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    turbo_gov uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_ratio(req_ratio),
        .pwr_meas(pwr_meas), .pwr_limit(pwr_limit), .budget_cap(budget_cap),
        .active_cores(active_cores), .thermal_hot(thermal_hot), .ratio_out(ratio_out)
    );

    // Vector layout: {req, meas, limit, cores, cap, expected ratio after the tick}
    localparam int NV = 33;
    localparam logic [47:0] VEC [NV] = '{
        {8'd20, 8'd10, 8'd10, 8'd4, 8'd40, 8'd20},  // 0  R3 follow OS
        {8'd8,  8'd10, 8'd10, 8'd4, 8'd40, 8'd12},  // 1  R3 clamp to PN
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd30},  // 2  R4 jump to P1
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd30},  // 3  R7 no credit, at limit: hold
        {8'd50, 8'd0,  8'd10, 8'd4, 8'd40, 8'd30},  // 4  R2 credit builds to 10
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd31},  // 5  R5
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd32},  // 6  R5
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd33},  // 7  R5
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd34},  // 8  R5
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd34},  // 9  R6 4-core ceiling
        {8'd50, 8'd10, 8'd10, 8'd1, 8'd40, 8'd35},  // 10 R6 1-core row
        {8'd50, 8'd20, 8'd10, 8'd1, 8'd40, 8'd36},  // 11 R2 credit spent to 0
        {8'd50, 8'd20, 8'd10, 8'd1, 8'd40, 8'd35},  // 12 R7 step down
        {8'd50, 8'd20, 8'd10, 8'd1, 8'd40, 8'd34},  // 13 R7
        {8'd50, 8'd10, 8'd10, 8'd4, 8'd40, 8'd34},  // 14 R6 at ceiling
        {8'd50, 8'd0,  8'd10, 8'd4, 8'd15, 8'd34},  // 15 R2 credit 10
        {8'd50, 8'd0,  8'd10, 8'd4, 8'd15, 8'd34},  // 16 R2 credit capped at 15
        {8'd50, 8'd15, 8'd10, 8'd1, 8'd15, 8'd35},  // 17 R5 credit 10
        {8'd50, 8'd15, 8'd10, 8'd1, 8'd15, 8'd36},  // 18 R5 credit 5
        {8'd50, 8'd15, 8'd10, 8'd1, 8'd15, 8'd37},  // 19 R5 credit 0
        {8'd50, 8'd15, 8'd10, 8'd1, 8'd15, 8'd36},  // 20 R2 cap bounded the burst
        {8'd50, 8'd15, 8'd10, 8'd1, 8'd15, 8'd35},  // 21 R7
        {8'd50, 8'd15, 8'd10, 8'd4, 8'd15, 8'd34},  // 22 R6 drop to ceiling
        {8'd50, 8'd0,  8'd10, 8'd0, 8'd40, 8'd34},  // 23 R2 credit 10, hold
        {8'd50, 8'd10, 8'd10, 8'd0, 8'd40, 8'd35},  // 24 R6 0 cores uses 1-core row
        {8'd50, 8'd10, 8'd10, 8'd7, 8'd40, 8'd34},  // 25 R6 7 cores uses 4-core row
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd34},  // 26 R6 hold at ceiling, credit 0
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd33},  // 27 R7
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd32},  // 28 R7
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd31},  // 29 R7
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd30},  // 30 R7
        {8'd50, 8'd30, 8'd10, 8'd4, 8'd40, 8'd30},  // 31 R7 floor at P1
        {8'd25, 8'd10, 8'd10, 8'd4, 8'd40, 8'd25}   // 32 R3
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_cmp++;
        if (ratio_out !== exp) begin
            n_bad++;
            $display("FAIL %s: ratio_out=%0d expected=%0d", req, ratio_out, exp);
        end
    endtask

    // Drive one interval with a single-cycle tick; sample at the falling edge after the update.
    task automatic do_tick(input logic [7:0] rq, input logic [7:0] pm, input logic [7:0] pl,
                           input logic [2:0] nc, input logic [11:0] cap);
        req_ratio = rq; pwr_meas = pm; pwr_limit = pl; active_cores = nc; budget_cap = cap;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: ratio_out=%0d expected=completion", ratio_out);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset ratio", 8'd12);

        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][26:24] == 3'd0 ? VEC[i][18:16] : VEC[i][18:16],
                    {4'd0, VEC[i][15:8]});
            check($sformatf("vector %0d (R2-R7)", i), VEC[i][7:0]);
        end

        // R9: inputs change without a tick; the ratio must hold.
        req_ratio = 8'd14; active_cores = 3'd1; pwr_meas = 8'd90;
        repeat (4) @(negedge clk);
        check("R9 no tick hold", 8'd25);

        // R8: throttle without a tick forces PN on the next edge, then holds through ticks.
        thermal_hot = 1'b1;
        @(negedge clk);
        check("R8 throttle immediate", 8'd12);
        do_tick(8'd50, 8'd0, 8'd10, 3'd1, 12'd40);
        check("R8 throttle over turbo request", 8'd12);
        thermal_hot = 1'b0;
        @(negedge clk);
        check("R9 release without tick", 8'd12);

        // R1: reset mid-run returns to PN and clears the credit.
        do_reset();
        check("R1 mid-run reset", 8'd12);

        // R2: headroom seen with no tick must not build credit.
        req_ratio = 8'd50; pwr_meas = 8'd0; pwr_limit = 8'd10; budget_cap = 12'd40;
        repeat (5) @(negedge clk);
        do_tick(8'd50, 8'd10, 8'd10, 3'd1, 12'd40);
        check("R4 jump to P1 after reset", 8'd30);
        do_tick(8'd50, 8'd10, 8'd10, 3'd1, 12'd40);
        check("R2 no credit without tick", 8'd30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule